// File: doc/BRIEF.md
# Register Write Command Packer

This block turns a stream of high-level display-programming requests into a packed instruction image. It writes that image, one 32-bit word per cycle, into a local RAM through a plain write port. The requests are register writes, byte-masked writes, indexed bursts, timed waits, no-ops, interrupts, subroutine calls and a finish marker. Every instruction is a pair of words that starts at an even word index. A free-position pointer, counted in words, tracks where the next word goes.

Back-to-back indexed writes to the same register share one header. The header's count word is rewritten in place each time a data word is appended. Subroutine calls are kept out of the last two quadword slots of a 64-byte line, and the rest of the line after a call is zero-filled. A finish request pads the image to a line boundary. When an instruction does not fit, it is refused and a sticky overflow flag rises.

The producer offers one request at a time with a valid/ready pair. The consumer reads the tail position once the producer is done.

Top module: `cmd_packer`

## Requirements
- R1: After reset, `reqReady` is 1, `tailPos` is 0, `overflow` is 0, and no RAM write occurs until a request is accepted.
- R2: A request is taken only on a cycle where `reqValid` and `reqReady` are both 1. `reqReady` is 0 on the next cycle and stays 0 until every RAM write for that request has been issued. RAM writes happen only while `reqReady` is 0.
- R3: An instruction emit, or an indexed data append, is refused when the pointer exceeds depth minus 2. A refused step writes nothing and leaves the pointer unchanged. It also sets `overflow`, and the rest of that request is dropped.
- R4: A register write (kind 0) places `reqData` at the even word and `{8'h01, 4'hF, reg[19:0]}` at the following word.
- R5: A masked write (kind 1) is encoded like a register write, except that bits 23:20 hold byte enables taken from the mask in `reqAux`. Enable i is 1 when any bit of byte lane i of the mask is 1.
- R6: A wait request (kind 3) for N stores N+1 in the lower word and `32'h02000000` in the upper word. A no-op (kind 4) stores two zero words. An interrupt (kind 5) stores 0 and `32'h07000000`.
- R7: An indexed write (kind 2) that cannot join the previous instruction emits a header. Its upper word is `{8'h09, 4'h0, reg}`, and its lower word is a count that ends as 1 after the first data word.
- R8: An indexed write joins the previous instruction only if that instruction's upper word is exactly the indexed header for the same register. On joining, the header's lower word is rewritten with count+1 and the data word is appended at the pointer. A different register, or any other instruction in between, starts a new header.
- R9: After an indexed append, an odd pointer causes a zero to be written at the pointer without advancing it. The next instruction then starts at the pointer rounded up to even.
- R10: With an empty buffer (pointer 0), an indexed write always emits a new header, whatever the RAM holds.
- R11: A finish request (kind 7) zero-fills from the pointer up to the next multiple of 16 words. Zero-filled words count as no-ops, so a later indexed write starts a new header.
- R12: For a call (kind 6), let the even-rounded pointer sit at word offset 12 or 14 of its 16-word line. Then the rest of the line is zero-filled and the call goes at the next line start; otherwise the call goes at the even-rounded pointer. After the call, the rest of its line is zero-filled.
- R13: A call is the 64-bit word `{8'h0C, 4'h0, head[31:6], tail[31:6]}`, with head taken from `reqData` and tail from `reqAux`. Bits 31:0 go to the lower word.
- R14: Once set, `overflow` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block can take a request |
| reqKind | input | 3 | 0 write, 1 masked, 2 indexed, 3 wait, 4 no-op, 5 interrupt, 6 call, 7 finish |
| reqReg | input | 20 | Target register offset |
| reqData | input | 32 | Write value, wait count, or call head byte address |
| reqAux | input | 32 | Byte mask for masked write, or call tail byte address |
| ramWe | output | 1 | RAM write strobe |
| ramAddr | output | $clog2(DEPTH_DW) | RAM word address |
| ramWdata | output | 32 | RAM write data |
| tailPos | output | $clog2(DEPTH_DW+1) | Free-position pointer in words |
| overflow | output | 1 | Sticky refusal flag |

## Verification
The hardest case to reach is an indexed header that fits in the last two words of the buffer while its data word does not. That leaves a header with count 0 and the overflow flag set. The stimulus gets there by first steering the pointer to odd positions with indexed bursts, padding lines with finish and both call placements, and then issuing exactly enough plain writes to land on depth minus 2. The empty-buffer rule is exercised after a second reset, with the RAM still holding the old image.

// File: rtl/cmdpk_pkg.sv
package cmdpk_pkg;

  typedef enum logic [2:0] {
    K_WRITE   = 3'd0,
    K_MASKED  = 3'd1,
    K_INDEXED = 3'd2,
    K_WAIT    = 3'd3,
    K_NOOP    = 3'd4,
    K_IRQ     = 3'd5,
    K_CALL    = 3'd6,
    K_FINISH  = 3'd7
  } req_kind_e;

  localparam logic [7:0] OPC_WRITE = 8'h01;
  localparam logic [7:0] OPC_WAIT  = 8'h02;
  localparam logic [7:0] OPC_IRQ   = 8'h07;
  localparam logic [7:0] OPC_INDEX = 8'h09;
  localparam logic [7:0] OPC_CALL  = 8'h0C;

  // words per 64-byte line
  localparam int LINE_DW = 16;

  typedef struct packed {
    logic load;        // latch request fields
    logic wrLo;        // lower word at even pointer
    logic wrHi;        // upper word, record as previous instruction
    logic wrCnt;       // bump header count, rewrite it
    logic wrData;      // append indexed data word
    logic wrZeroAhead; // zero at pointer, no advance
    logic wrZero;      // pad word, advance
    logic setOvf;      // refusal
  } dp_ctl_t;

  function automatic logic [3:0] mask_to_be(input logic [31:0] m);
    return {|m[31:24], |m[23:16], |m[15:8], |m[7:0]};
  endfunction

endpackage

// File: rtl/cmd_packer_dp.sv
module cmd_packer_dp
  import cmdpk_pkg::*;
#(
  parameter int DEPTH_DW = 64,
  parameter int AW = $clog2(DEPTH_DW),
  parameter int PW = $clog2(DEPTH_DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  dp_ctl_t       ctl,
  input  logic [2:0]    reqKind,
  input  logic [19:0]   reqReg,
  input  logic [31:0]   reqData,
  input  logic [31:0]   reqAux,
  output logic          roomOk,
  output logic          coalesce,
  output logic          callPrePad,
  output logic          lineDone,
  output logic          ptrOdd,
  output logic          ramWe,
  output logic [AW-1:0] ramAddr,
  output logic [31:0]   ramWdata,
  output logic [PW-1:0] freePos,
  output logic          ovf
);
  localparam int LW = $clog2(LINE_DW);

  req_kind_e   kindQ;
  logic [19:0] regQ;
  logic [31:0] dataQ, auxQ;
  logic [AW-1:0] insStart;
  logic [31:0] insLo, insHi;
  logic [PW-1:0] ptrEven;
  logic [LW-1:0] evenOff;
  logic [31:0] instLo, instHi, headerHi;
  logic [63:0] callWord;

  assign ptrEven    = freePos + {{(PW-1){1'b0}}, freePos[0]};
  assign evenOff    = ptrEven[LW-1:0];
  assign headerHi   = {OPC_INDEX, 4'h0, regQ};
  assign callWord   = {OPC_CALL, 4'h0, dataQ[31:6], auxQ[31:6]};
  assign roomOk     = freePos <= PW'(DEPTH_DW - 2);
  assign coalesce   = (freePos != '0) && (insHi == headerHi);
  assign callPrePad = (evenOff != '0) && (evenOff >= LW'(LINE_DW - 4));
  assign lineDone   = freePos[LW-1:0] == '0;
  assign ptrOdd     = freePos[0];

  always_comb begin
    instLo = '0;
    instHi = '0;
    case (kindQ)
      K_WRITE:   begin instLo = dataQ; instHi = {OPC_WRITE, 4'hF, regQ}; end
      K_MASKED:  begin instLo = dataQ; instHi = {OPC_WRITE, mask_to_be(auxQ), regQ}; end
      K_INDEXED: instHi = headerHi;
      K_WAIT:    begin instLo = dataQ + 32'd1; instHi = {OPC_WAIT, 24'h0}; end
      K_IRQ:     instHi = {OPC_IRQ, 24'h0};
      K_CALL:    begin instLo = callWord[31:0]; instHi = callWord[63:32]; end
      default:   ;
    endcase
  end

  always_comb begin
    ramWe    = ctl.wrLo | ctl.wrHi | ctl.wrCnt | ctl.wrData | ctl.wrZeroAhead | ctl.wrZero;
    ramAddr  = freePos[AW-1:0];
    ramWdata = '0;
    if (ctl.wrLo) begin
      ramAddr  = ptrEven[AW-1:0];
      ramWdata = instLo;
    end else if (ctl.wrHi) begin
      ramWdata = instHi;
    end else if (ctl.wrCnt) begin
      ramAddr  = insStart;
      ramWdata = insLo + 32'd1;
    end else if (ctl.wrData) begin
      ramWdata = dataQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kindQ    <= K_NOOP;
      regQ     <= '0;
      dataQ    <= '0;
      auxQ     <= '0;
      freePos  <= '0;
      insStart <= '0;
      insLo    <= '0;
      insHi    <= '0;
      ovf      <= 1'b0;
    end else begin
      if (ctl.load) begin
        kindQ <= req_kind_e'(reqKind);
        regQ  <= reqReg;
        dataQ <= reqData;
        auxQ  <= reqAux;
      end
      if (ctl.wrLo) begin
        freePos  <= ptrEven + PW'(1);
        insStart <= ptrEven[AW-1:0];
        insLo    <= instLo;
      end
      if (ctl.wrHi) begin
        freePos <= freePos + PW'(1);
        insHi   <= instHi;
      end
      if (ctl.wrCnt) insLo <= insLo + 32'd1;
      if (ctl.wrData) freePos <= freePos + PW'(1);
      if (ctl.wrZero) begin
        freePos <= freePos + PW'(1);
        insHi   <= '0;
      end
      if (ctl.setOvf) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/cmd_packer_ctrl.sv
module cmd_packer_ctrl
  import cmdpk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  input  logic [2:0] reqKind,
  input  logic       roomOk,
  input  logic       coalesce,
  input  logic       callPrePad,
  input  logic       lineDone,
  input  logic       ptrOdd,
  output logic       reqReady,
  output dp_ctl_t    ctl
);
  typedef enum logic [2:0] {
    S_IDLE, S_DECIDE, S_EMIT_LO, S_EMIT_HI, S_IDX_CNT, S_IDX_DATA, S_IDX_ZERO, S_PAD
  } state_e;

  state_e    state, stateNxt;
  req_kind_e kindQ;
  logic      preQ, preNxt;

  assign reqReady = state == S_IDLE;

  always_comb begin
    ctl      = '0;
    stateNxt = state;
    preNxt   = preQ;
    case (state)
      S_IDLE: if (reqValid) begin
        ctl.load = 1'b1;
        stateNxt = S_DECIDE;
      end
      S_DECIDE: begin
        case (kindQ)
          K_FINISH:  begin stateNxt = S_PAD; preNxt = 1'b0; end
          K_CALL:    if (callPrePad) begin stateNxt = S_PAD; preNxt = 1'b1; end
                     else stateNxt = S_EMIT_LO;
          K_INDEXED: stateNxt = coalesce ? S_IDX_CNT : S_EMIT_LO;
          default:   stateNxt = S_EMIT_LO;
        endcase
      end
      S_EMIT_LO: if (!roomOk) begin
        ctl.setOvf = 1'b1;
        stateNxt   = S_IDLE;
      end else begin
        ctl.wrLo = 1'b1;
        stateNxt = S_EMIT_HI;
      end
      S_EMIT_HI: begin
        ctl.wrHi = 1'b1;
        if (kindQ == K_INDEXED) stateNxt = S_IDX_CNT;
        else if (kindQ == K_CALL) begin stateNxt = S_PAD; preNxt = 1'b0; end
        else stateNxt = S_IDLE;
      end
      S_IDX_CNT: if (!roomOk) begin
        ctl.setOvf = 1'b1;
        stateNxt   = S_IDLE;
      end else begin
        ctl.wrCnt = 1'b1;
        stateNxt  = S_IDX_DATA;
      end
      S_IDX_DATA: begin
        ctl.wrData = 1'b1;
        stateNxt   = ptrOdd ? S_IDLE : S_IDX_ZERO;
      end
      S_IDX_ZERO: begin
        ctl.wrZeroAhead = 1'b1;
        stateNxt        = S_IDLE;
      end
      S_PAD: if (lineDone) begin
        stateNxt = preQ ? S_EMIT_LO : S_IDLE;
        preNxt   = 1'b0;
      end else begin
        ctl.wrZero = 1'b1;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      kindQ <= K_NOOP;
      preQ  <= 1'b0;
    end else begin
      state <= stateNxt;
      preQ  <= preNxt;
      if (ctl.load) kindQ <= req_kind_e'(reqKind);
    end
  end
endmodule

// File: rtl/cmd_packer.sv
module cmd_packer
  import cmdpk_pkg::*;
#(
  parameter int DEPTH_DW = 64,
  localparam int AW = $clog2(DEPTH_DW),
  localparam int PW = $clog2(DEPTH_DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reqValid,
  output logic          reqReady,
  input  logic [2:0]    reqKind,
  input  logic [19:0]   reqReg,
  input  logic [31:0]   reqData,
  input  logic [31:0]   reqAux,
  output logic          ramWe,
  output logic [AW-1:0] ramAddr,
  output logic [31:0]   ramWdata,
  output logic [PW-1:0] tailPos,
  output logic          overflow
);
  dp_ctl_t ctl;
  logic roomOk, coalesce, callPrePad, lineDone, ptrOdd;

  cmd_packer_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqKind(reqKind),
    .roomOk(roomOk), .coalesce(coalesce), .callPrePad(callPrePad),
    .lineDone(lineDone), .ptrOdd(ptrOdd), .reqReady(reqReady), .ctl(ctl)
  );

  cmd_packer_dp #(.DEPTH_DW(DEPTH_DW), .AW(AW), .PW(PW)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .reqKind(reqKind), .reqReg(reqReg),
    .reqData(reqData), .reqAux(reqAux), .roomOk(roomOk), .coalesce(coalesce),
    .callPrePad(callPrePad), .lineDone(lineDone), .ptrOdd(ptrOdd),
    .ramWe(ramWe), .ramAddr(ramAddr), .ramWdata(ramWdata),
    .freePos(tailPos), .ovf(overflow)
  );
endmodule

// File: rtl/cmd_packer_chk.sv
module cmd_packer_chk #(
  parameter int PW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reqValid,
  input logic          reqReady,
  input logic          ramWe,
  input logic [PW-1:0] tailPos,
  input logic          overflow
);
  // R2: RAM writes only while a request is in progress
  p_write_only_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ramWe |-> !reqReady);

  // R2: an accepted request makes the block busy on the next cycle
  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady) |=> !reqReady);

  // R2: the free pointer never moves backwards
  p_tail_forward_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tailPos) |-> tailPos > $past(tailPos));

  // R3: a refusal writes nothing in the cycle it is decided
  p_refuse_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> !$past(ramWe));

  // R14: overflow is sticky
  p_no_overflow_clear_r14: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
endmodule

bind cmd_packer cmd_packer_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
  .ramWe(ramWe), .tailPos(tailPos), .overflow(overflow)
);

// File: tb/cmd_packer_test.sv
`timescale 1ns/1ps
module cmd_packer_test;
  import cmdpk_pkg::*;

  localparam int DEPTH = 128;
  localparam int AW = $clog2(DEPTH);
  localparam int PW = $clog2(DEPTH + 1);
  localparam logic [31:0] JUNK = 32'hDEADBEEF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [2:0] reqKind = '0;
  logic [19:0] reqReg = '0;
  logic [31:0] reqData = '0, reqAux = '0;
  logic ramWe;
  logic [AW-1:0] ramAddr;
  logic [31:0] ramWdata;
  logic [PW-1:0] tailPos;
  logic overflow;

  int compared = 0;
  int mismatched = 0;
  string phaseTag = "R1";

  logic [31:0] shadow [DEPTH];
  logic [31:0] expMem [DEPTH];
  bit shadowInit = 1'b0;
  int expTail = 0;
  bit expOvf = 1'b0;
  int mStart = 0;
  logic [31:0] mLo = '0, mHi = '0;

  always #2.5 clk = ~clk;

  cmd_packer #(.DEPTH_DW(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqKind(reqKind), .reqReg(reqReg), .reqData(reqData), .reqAux(reqAux),
    .ramWe(ramWe), .ramAddr(ramAddr), .ramWdata(ramWdata),
    .tailPos(tailPos), .overflow(overflow)
  );

  // RAM seen by the block, pre-filled with junk
  always @(posedge clk) begin
    if (!shadowInit) begin
      for (int i = 0; i < DEPTH; i++) shadow[i] <= JUNK;
      shadowInit <= 1'b1;
    end else if (ramWe) shadow[ramAddr] <= ramWdata;
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // whole-state comparison on every idle clock
  always @(negedge clk) begin
    if (rst_n && shadowInit && reqReady && !reqValid) begin
      int bad = 0;
      for (int i = 0; i < DEPTH; i++) if (shadow[i] !== expMem[i]) bad++;
      compared++;
      if (bad != 0 || int'(tailPos) != expTail || overflow !== expOvf) begin
        mismatched++;
        $display("FAIL %s image words off=%0d tail got=%0d exp=%0d ovf got=%b exp=%b",
                 phaseTag, bad, tailPos, expTail, overflow, expOvf);
      end
    end
  end

  // ---------------- reference model ----------------
  task automatic mEmit(input logic [31:0] lo, input logic [31:0] hi, output bit ok);
    ok = 1'b0;
    if (expTail > DEPTH - 2) begin expOvf = 1'b1; return; end
    expTail = expTail + (expTail % 2);
    expMem[expTail] = lo;
    expMem[expTail + 1] = hi;
    mStart = expTail; mLo = lo; mHi = hi;
    expTail += 2;
    ok = 1'b1;
  endtask

  task automatic mPad();
    while (expTail % 16 != 0) begin
      expMem[expTail] = '0;
      expTail++;
      mHi = '0;
    end
  endtask

  task automatic model(input logic [2:0] k, input logic [19:0] r,
                       input logic [31:0] d, input logic [31:0] a);
    bit ok;
    logic [3:0] be;
    logic [63:0] w;
    logic [31:0] hdr;
    case (k)
      3'd0: mEmit(d, {8'h01, 4'hF, r}, ok);
      3'd1: begin
        be = '0;
        for (int lane = 0; lane < 4; lane++) if (a[lane*8 +: 8] != 8'h00) be[lane] = 1'b1;
        mEmit(d, {8'h01, be, r}, ok);
      end
      3'd2: begin
        hdr = {8'h09, 4'h0, r};
        ok = 1'b1;
        if (!(expTail != 0 && mHi == hdr)) mEmit(32'h0, hdr, ok);
        if (ok) begin
          if (expTail > DEPTH - 2) expOvf = 1'b1;
          else begin
            mLo++;
            expMem[mStart] = mLo;
            expMem[expTail] = d;
            expTail++;
            if (expTail % 2 == 1) expMem[expTail] = '0;
          end
        end
      end
      3'd3: mEmit(d + 1, 32'h02000000, ok);
      3'd4: mEmit(32'h0, 32'h0, ok);
      3'd5: mEmit(32'h0, 32'h07000000, ok);
      3'd6: begin
        w = {8'h0C, 4'h0, d[31:6], a[31:6]};
        if (((expTail + expTail % 2) % 16) >= 12) mPad();
        mEmit(w[31:0], w[63:32], ok);
        if (ok) mPad();
      end
      default: mPad();
    endcase
  endtask

  task automatic send(input req_kind_e k, input logic [19:0] r,
                      input logic [31:0] d, input logic [31:0] a);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqKind = k; reqReg = r; reqData = d; reqAux = a;
    reqValid = 1'b1;
    @(posedge clk);
    #1;
    reqValid = 1'b0;
    model(k, r, d, a);
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] cw;
    for (int i = 0; i < DEPTH; i++) expMem[i] = JUNK;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", {31'b0, reqReady}, 32'd1);
    chk("R1 tail", 32'(tailPos), 32'd0);
    chk("R1 overflow", {31'b0, overflow}, 32'd0);

    phaseTag = "R4";
    send(K_WRITE, 20'h12345, 32'hCAFE0001, 32'h0);
    chk("R2 busy after accept", {31'b0, reqReady}, 32'd0);
    waitIdle();
    chk("R4 lower", shadow[0], 32'hCAFE0001);
    chk("R4 upper", shadow[1], 32'h01F12345);

    phaseTag = "R5";
    send(K_MASKED, 20'h00ABC, 32'h11, 32'h00FF0000);
    send(K_MASKED, 20'h00ABC, 32'h22, 32'hFF0000FF);
    send(K_MASKED, 20'h00ABC, 32'h33, 32'h0);
    waitIdle();
    chk("R5 lane2", shadow[3], 32'h01400ABC);
    chk("R5 lanes3,0", shadow[5], 32'h01900ABC);
    chk("R5 none", shadow[7], 32'h01000ABC);

    phaseTag = "R6";
    send(K_WAIT, 20'h0, 32'd5, 32'h0);
    send(K_NOOP, 20'h0, 32'h0, 32'h0);
    send(K_IRQ, 20'h0, 32'h0, 32'h0);
    waitIdle();
    chk("R6 wait count", shadow[8], 32'd6);
    chk("R6 wait op", shadow[9], 32'h02000000);
    chk("R6 noop", shadow[11], 32'h0);
    chk("R6 irq op", shadow[13], 32'h07000000);

    phaseTag = "R8";
    send(K_INDEXED, 20'h00100, 32'hA1, 32'h0);
    send(K_INDEXED, 20'h00100, 32'hA2, 32'h0);
    send(K_INDEXED, 20'h00100, 32'hA3, 32'h0);
    waitIdle();
    chk("R7 header", shadow[15], 32'h09000100);
    chk("R8 count", shadow[14], 32'd3);
    chk("R8 last data", shadow[18], 32'hA3);
    chk("R9 zero ahead", shadow[19], 32'h0);
    chk("R9 odd tail", 32'(tailPos), 32'd19);

    send(K_INDEXED, 20'h00200, 32'hB1, 32'h0);
    send(K_INDEXED, 20'h00200, 32'hB2, 32'h0);
    waitIdle();
    chk("R9 header aligned", shadow[21], 32'h09000200);
    chk("R8 joined count", shadow[20], 32'd2);
    chk("R8 joined data", shadow[23], 32'hB2);

    send(K_WRITE, 20'h00200, 32'hC0, 32'h0);
    send(K_INDEXED, 20'h00200, 32'hB3, 32'h0);
    waitIdle();
    chk("R8 new header after write", shadow[26], 32'd1);

    phaseTag = "R11";
    send(K_FINISH, 20'h0, 32'h0, 32'h0);
    waitIdle();
    chk("R11 tail", 32'(tailPos), 32'd32);
    chk("R11 pad", shadow[31], 32'h0);
    send(K_INDEXED, 20'h00200, 32'hB4, 32'h0);
    waitIdle();
    chk("R11 new header", shadow[32], 32'd1);

    phaseTag = "R12";
    send(K_CALL, 20'h0, 32'h00012340, 32'h00045680);
    waitIdle();
    cw = {8'h0C, 4'h0, 26'h00012340 >> 6, 26'h00045680 >> 6};
    cw = {8'h0C, 4'h0, 26'(32'h00012340 >> 6), 26'(32'h00045680 >> 6)};
    chk("R13 call lower", shadow[36], cw[31:0]);
    chk("R13 call upper", shadow[37], cw[63:32]);
    chk("R12 post pad", shadow[47], 32'h0);
    chk("R12 tail", 32'(tailPos), 32'd48);
    for (int i = 0; i < 6; i++) send(K_WRITE, 20'h00010, 32'(i), 32'h0);
    send(K_CALL, 20'h0, 32'h00012340, 32'h00045680);
    waitIdle();
    chk("R12 pre pad", shadow[62], 32'h0);
    chk("R12 call at line", shadow[65], cw[63:32]);
    chk("R12 tail after", 32'(tailPos), 32'd80);

    phaseTag = "R3";
    for (int i = 0; i < 23; i++) send(K_WRITE, 20'h00020, 32'(i), 32'h0);
    send(K_INDEXED, 20'h00300, 32'hD1, 32'h0);
    waitIdle();
    chk("R3 header count 0", shadow[126], 32'h0);
    chk("R3 overflow", {31'b0, overflow}, 32'd1);
    chk("R3 tail", 32'(tailPos), 32'd128);
    phaseTag = "R14";
    send(K_WRITE, 20'h00020, 32'h99, 32'h0);
    send(K_FINISH, 20'h0, 32'h0, 32'h0);
    waitIdle();
    chk("R14 still set", {31'b0, overflow}, 32'd1);

    phaseTag = "R10";
    @(negedge clk);
    rst_n = 1'b0;
    expTail = 0; expOvf = 1'b0; mHi = '0; mLo = '0; mStart = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    send(K_INDEXED, 20'h12345, 32'hE1, 32'h0);
    waitIdle();
    chk("R10 header", shadow[1], 32'h09012345);
    chk("R10 count", shadow[0], 32'd1);
    chk("R10 data", shadow[2], 32'hE1);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule